// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reason the chip may have to restart and turns them into one system reset line. It is released in step with the system clock after a fixed hold-off. A power-good input acts as the power-on/brown-out source. While it is low, everything is held in reset. Once it rises, a synchronizer and a hold-off counter set the release time. The hold-off is longer when the crystal-oscillator option is selected.

The other sources depend on the operating mode. In normal or halt mode, the block accepts:
- the external pin;
- a watchdog time-out, but only when the watchdog is configured to reset;
- a reset bit written by the debugger.

In stop mode, the block accepts:
- the external pin;
- the debug pin held low.

Both pins pass through a two-flop synchronizer and then a low-width filter. The filter drops pulses shorter than three clocks. A debugger-initiated reset restarts the system but leaves the debug logic running, because the separate debug reset follows power-good only.

When the block leaves reset, it raises a one-cycle strobe that starts the reset-vector fetch. A four-bit status register records the cause of the latest reset. Software clears its bits by writing 1. The block has no data stream, so every pin is plain control or status.

Top module: `rst_seq_top`

## Requirements
- R1: While `pwr_good` is low, `sys_rst_n` and `dbg_rst_n` are 0 at once, without waiting for a clock edge, and `rst_status` reads 4'b0001.
- R2: After `pwr_good` rises, `sys_rst_n` goes to 1 exactly HOLD_RC+2 clock edges later when `xtal_sel`=0, or HOLD_XTAL+2 edges later when `xtal_sel`=1. Two of those edges are synchronizer delay. `dbg_rst_n` goes to 1 after 2 edges.
- R3: In both modes, `ext_rst_n` causes a reset only if it is low at MIN_LOW (default 3) or more consecutive rising edges. A shorter low pulse leaves `sys_rst_n` at 1.
- R4: In normal mode (`op_stop`=0), a `wdt_expire` pulse with `wdt_rst_en`=1 causes a reset. A pulse with `wdt_rst_en`=0 is ignored, and any `wdt_expire` in stop mode is ignored.
- R5: In normal mode, `dbg_rst_req`=1 causes a system reset while `dbg_rst_n` stays 1. In stop mode, `dbg_rst_req` is ignored.
- R6: In stop mode, `dbg_pin_n` held low for MIN_LOW or more edges causes a reset. In normal mode, the debug pin is ignored.
- R7: Each accepted request drives `sys_rst_n` to 0 at the next edge and restarts the full hold-off. `sys_rst_n` stays 0 for as long as the request persists.
- R8: `vec_fetch` is 1 for exactly one cycle: the first cycle in which `sys_rst_n` is 1 after a reset.
- R9: `rst_status` bit 0 means power-on, bit 1 watchdog, bit 2 external pin, and bit 3 debugger (the debug bit or the debug pin). Each accepted request sets the bits of its own causes and clears all other bits.
- R10: A 1 in a bit of `sts_clr` clears that bit of `rst_status` at the next edge. A request in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good indication; low forces power-on reset |
| xtal_sel | input | 1 | Crystal option selected; selects the long hold-off |
| op_stop | input | 1 | 1 = stop mode, 0 = normal or halt mode |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| wdt_rst_en | input | 1 | Watchdog configured to reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| dbg_rst_req | input | 1 | Reset bit from the debugger |
| dbg_pin_n | input | 1 | Debug pin, active low, asynchronous |
| sts_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| sys_rst_n | output | 1 | System reset, active low |
| dbg_rst_n | output | 1 | Debug-logic reset, active low |
| vec_fetch | output | 1 | One-cycle reset-vector fetch strobe |
| rst_status | output | 4 | Sticky reset-cause bits |

## Verification
The bench drives external-pin pulses of two and three cycles. A filter that is off by one would either reset on the short pulse or miss the long one. It fires the watchdog, the debugger bit and the debug pin in both modes. A wrong mode qualifier would then show up as a reset that should not occur, or as a missing one. It also drops power-good mid-sequence to catch an asynchronous path that waits for a clock. It measures the release edge for both oscillator choices, where a counter bound off by one moves `vec_fetch` by a cycle. Finally, it issues a clear in the same cycle as a new request, where the wrong precedence loses the fresh cause bit.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NCAUSE = 4;
  localparam int C_POR  = 0;
  localparam int C_WDT  = 1;
  localparam int C_PIN  = 2;
  localparam int C_DBG  = 3;
  typedef logic [NCAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rst_low_filt.sv
module rst_low_filt #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic hit
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW - 1);

  logic [CW-1:0] run;

  // run counts earlier consecutive low samples, saturating at LIM
  assign hit = !pin_s && (run >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (pin_s)    run <= '0;
    else if (run < LIM) run <= run + 1'b1;
  end

  generate
    if (MIN_LOW >= 3) begin : g_chk
      AST_FILT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!pin_s && $past(!pin_s) && $past(!pin_s, 2))); // R3
    end
  endgenerate
endmodule

// File: rtl/rst_holdoff.sv
module rst_holdoff #(
  parameter int HOLD_RC   = 64,
  parameter int HOLD_XTAL = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_sel,
  input  logic req,
  output logic active,
  output logic vf
);
  localparam int HMAX = (HOLD_XTAL > HOLD_RC) ? HOLD_XTAL : HOLD_RC;
  localparam int CW   = $clog2(HMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_len;
  logic          done;

  assign hold_len = xtal_sel ? CW'(HOLD_XTAL) : CW'(HOLD_RC);
  assign done     = (cnt >= hold_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b1;
      vf     <= 1'b0;
    end else begin
      vf <= active && !req && done;
      if (req) begin
        cnt    <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (done) active <= 1'b0;
        else      cnt    <= cnt + 1'b1;
      end
    end
  end

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(cnt) >= $past(hold_len) - CW'(1))); // R2
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int HOLD_RC   = 64,
  parameter int HOLD_XTAL = 4096,
  parameter int MIN_LOW   = 3
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       xtal_sel,
  input  logic       op_stop,
  input  logic       wdt_expire,
  input  logic       wdt_rst_en,
  input  logic       ext_rst_n,
  input  logic       dbg_rst_req,
  input  logic       dbg_pin_n,
  input  logic [3:0] sts_clr,
  output logic       sys_rst_n,
  output logic       dbg_rst_n,
  output logic       vec_fetch,
  output logic [3:0] rst_status
);
  import rst_seq_pkg::*;

  localparam int NPIN = 2;

  logic            por_n;
  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] pin_hit;
  logic            ext_hit, dbg_hit;
  cause_vec_t      cause;
  logic            req;
  logic            active;
  cause_vec_t      sts_q;

  // power-on: asynchronous assert, synchronous release
  rst_sync2 #(.RST_VAL(1'b0)) u_por (
    .clk(clk), .rst_n(pwr_good), .d(1'b1), .q(por_n));

  assign pin_raw = {dbg_pin_n, ext_rst_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    rst_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(por_n), .d(pin_raw[g]), .q(pin_s[g]));
    rst_low_filt #(.MIN_LOW(MIN_LOW)) u_filt (
      .clk(clk), .rst_n(por_n), .pin_s(pin_s[g]), .hit(pin_hit[g]));
  end

  assign ext_hit = pin_hit[0];
  assign dbg_hit = pin_hit[1];

  // mode-dependent acceptance of sources
  always_comb begin
    cause        = '0;
    cause[C_PIN] = ext_hit;
    cause[C_WDT] = !op_stop && wdt_expire && wdt_rst_en;
    cause[C_DBG] = op_stop ? dbg_hit : dbg_rst_req;
  end
  assign req = |cause;

  rst_holdoff #(.HOLD_RC(HOLD_RC), .HOLD_XTAL(HOLD_XTAL)) u_hold (
    .clk(clk), .rst_n(por_n), .xtal_sel(xtal_sel), .req(req),
    .active(active), .vf(vec_fetch));

  assign sys_rst_n = !active;
  assign dbg_rst_n = por_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   sts_q <= cause_vec_t'(1 << C_POR);
    else if (req) sts_q <= cause;
    else          sts_q <= sts_q & ~sts_clr;
  end
  assign rst_status = sts_q;

  AST_REQ_RST: assert property (@(posedge clk) disable iff (!por_n)
    req |=> !sys_rst_n); // R7
  AST_VF_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> vec_fetch); // R8
  AST_VF_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch |=> !vec_fetch); // R8
  AST_DBG_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    (dbg_rst_req && !op_stop) |=> dbg_rst_n); // R5
  AST_STOP_NO_WDT: assert property (@(posedge clk) disable iff (!por_n)
    (op_stop && wdt_expire && !ext_hit && !dbg_hit && sys_rst_n) |=> sys_rst_n); // R4
  AST_STS_NEW: assert property (@(posedge clk) disable iff (!por_n)
    (req && ext_hit) |=> rst_status[C_PIN]); // R9
endmodule

// File: tb/test_rst_seq_top.sv
module test_rst_seq_top;
  localparam int HR  = 20;
  localparam int HX  = 50;
  localparam int MIN = 3;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, xtal_sel = 1'b0, op_stop = 1'b0;
  logic wdt_expire = 1'b0, wdt_rst_en = 1'b0, ext_rst_n = 1'b1;
  logic dbg_rst_req = 1'b0, dbg_pin_n = 1'b1;
  logic [3:0] sts_clr = 4'b0;
  logic sys_rst_n, dbg_rst_n, vec_fetch;
  logic [3:0] rst_status;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit started = 0;

  always #5 clk = ~clk;

  rst_seq_top #(.HOLD_RC(HR), .HOLD_XTAL(HX), .MIN_LOW(MIN)) i_rst_seq_top (
    .clk(clk), .pwr_good(pwr_good), .xtal_sel(xtal_sel), .op_stop(op_stop),
    .wdt_expire(wdt_expire), .wdt_rst_en(wdt_rst_en), .ext_rst_n(ext_rst_n),
    .dbg_rst_req(dbg_rst_req), .dbg_pin_n(dbg_pin_n), .sts_clr(sts_clr),
    .sys_rst_n(sys_rst_n), .dbg_rst_n(dbg_rst_n), .vec_fetch(vec_fetch),
    .rst_status(rst_status));

  // behavioural reference model
  int m_p1, m_p2, m_e1, m_e2, m_d1, m_d2, m_ec, m_dc, m_cnt, m_act, m_vf, m_sts;

  task automatic model_clear();
    m_e1 = 1; m_e2 = 1; m_d1 = 1; m_d2 = 1; m_ec = 0; m_dc = 0;
    m_cnt = 0; m_act = 1; m_vf = 0; m_sts = 1;
  endtask

  always @(posedge clk) begin
    int he, hd, cause, hold;
    started = 1;
    if (!pwr_good) begin
      m_p1 = 0; m_p2 = 0; model_clear();
    end else if (m_p2 == 0) begin
      m_p2 = m_p1; m_p1 = 1; model_clear();
    end else begin
      he = (m_e2 == 0 && m_ec >= MIN - 1);
      hd = (m_d2 == 0 && m_dc >= MIN - 1);
      cause = 0;
      if (he) cause |= 4;
      if (!op_stop && wdt_expire && wdt_rst_en) cause |= 2;
      if (!op_stop && dbg_rst_req) cause |= 8;
      if (op_stop && hd) cause |= 8;
      hold = xtal_sel ? HX : HR;
      m_vf = (m_act == 1 && cause == 0 && m_cnt >= hold - 1);
      if (cause != 0) begin m_cnt = 0; m_act = 1; end
      else if (m_act == 1) begin
        if (m_cnt >= hold - 1) m_act = 0; else m_cnt++;
      end
      m_sts = (cause != 0) ? cause : (m_sts & ~int'(sts_clr));
      m_ec = (m_e2 == 1) ? 0 : ((m_ec < MIN - 1) ? m_ec + 1 : m_ec);
      m_dc = (m_d2 == 1) ? 0 : ((m_dc < MIN - 1) ? m_dc + 1 : m_dc);
      m_e2 = m_e1; m_e1 = ext_rst_n;
      m_d2 = m_d1; m_d1 = dbg_pin_n;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // every-cycle comparison, 3 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (started) begin
        if (!pwr_good) begin
          chk("R1", "sys_rst_n", int'(sys_rst_n), 0);
          chk("R1", "dbg_rst_n", int'(dbg_rst_n), 0);
          chk("R1", "rst_status", int'(rst_status), 1);
        end else begin
          chk(phase, "sys_rst_n", int'(sys_rst_n), 1 - m_act);
          chk(phase, "dbg_rst_n", int'(dbg_rst_n), m_p2);
          chk(phase, "vec_fetch", int'(vec_fetch), m_vf);
          chk(phase, "rst_status", int'(rst_status), m_sts);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200; i++) begin
      if (sys_rst_n) break;
      @(negedge clk); #3;
    end
  endtask

  task automatic pin_pulse(bit dbg, int w);
    @(negedge clk);
    if (dbg) dbg_pin_n = 1'b0; else ext_rst_n = 1'b0;
    cyc(w);
    if (dbg) dbg_pin_n = 1'b1; else ext_rst_n = 1'b1;
  endtask

  task automatic measure_release(string tag, int exp);
    int n;
    n = 0;
    @(negedge clk); pwr_good = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #3; n++;
      if (sys_rst_n) break;
    end
    chk(tag, "release edges", n, exp);
    chk("R8", "vec_fetch at release", int'(vec_fetch), 1);
    @(negedge clk); #3;
    chk("R8", "vec_fetch after release", int'(vec_fetch), 0);
  endtask

  initial begin
    // R1: power not good
    cyc(4); #3;
    chk("R1", "sys_rst_n low", int'(sys_rst_n), 0);
    chk("R1", "status por", int'(rst_status), 1);
    // R2: release timing, short hold-off
    phase = "R2";
    measure_release("R2", HR + 2);

    // R3: short pulse ignored, long pulse accepted
    phase = "R3";
    pin_pulse(0, MIN - 1); cyc(8); #3;
    chk("R3", "short pulse ignored", int'(sys_rst_n), 1);
    pin_pulse(0, MIN); cyc(4); #3;
    chk("R3", "long pulse resets", int'(sys_rst_n), 0);
    chk("R9", "pin cause", int'(rst_status), 4);
    wait_release();

    // R10: write-one-to-clear
    phase = "R10";
    @(negedge clk); sts_clr = 4'b0100;
    @(negedge clk); sts_clr = 4'b0; #3;
    chk("R10", "cleared", int'(rst_status), 0);

    // R4: watchdog
    phase = "R4";
    @(negedge clk); wdt_expire = 1'b1; wdt_rst_en = 1'b0;
    @(negedge clk); wdt_expire = 1'b0; cyc(3); #3;
    chk("R4", "wdt disabled ignored", int'(sys_rst_n), 1);
    @(negedge clk); op_stop = 1'b1; wdt_expire = 1'b1; wdt_rst_en = 1'b1;
    @(negedge clk); wdt_expire = 1'b0; op_stop = 1'b0; cyc(3); #3;
    chk("R4", "wdt in stop ignored", int'(sys_rst_n), 1);
    @(negedge clk); wdt_expire = 1'b1; sts_clr = 4'b1111;
    @(negedge clk); wdt_expire = 1'b0; sts_clr = 4'b0; #3;
    chk("R4", "wdt resets", int'(sys_rst_n), 0);
    chk("R10", "request beats clear", int'(rst_status), 2);
    wait_release();

    // R5: debugger bit
    phase = "R5";
    @(negedge clk); dbg_rst_req = 1'b1;
    @(negedge clk); dbg_rst_req = 1'b0; #3;
    chk("R5", "dbg bit resets", int'(sys_rst_n), 0);
    chk("R5", "debug logic kept", int'(dbg_rst_n), 1);
    chk("R9", "dbg cause", int'(rst_status), 8);
    wait_release();
    @(negedge clk); op_stop = 1'b1; dbg_rst_req = 1'b1;
    @(negedge clk); dbg_rst_req = 1'b0; cyc(2); #3;
    chk("R5", "dbg bit in stop ignored", int'(sys_rst_n), 1);

    // R6: debug pin
    phase = "R6";
    @(negedge clk); op_stop = 1'b0;
    pin_pulse(1, 6); cyc(4); #3;
    chk("R6", "debug pin in normal ignored", int'(sys_rst_n), 1);
    @(negedge clk); op_stop = 1'b1;
    pin_pulse(1, MIN); cyc(4); #3;
    chk("R6", "debug pin in stop resets", int'(sys_rst_n), 0);
    wait_release();
    @(negedge clk); op_stop = 1'b0;

    // R7: persistent request holds reset, hold-off restarts
    phase = "R7";
    pin_pulse(0, 30); #3;
    chk("R7", "held while pin low", int'(sys_rst_n), 0);
    cyc(HR); #3;
    chk("R7", "hold-off restarted", int'(sys_rst_n), 0);
    wait_release();

    // R1 asynchronous drop mid-sequence, then R2 long hold-off
    phase = "R2";
    @(negedge clk); pwr_good = 1'b0; #1;
    chk("R1", "async assert", int'(sys_rst_n), 0);
    chk("R1", "dbg async assert", int'(dbg_rst_n), 0);
    xtal_sel = 1'b1; cyc(3);
    measure_release("R2", HX + 2);
    cyc(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule